// File: doc/BRIEF.md
# External Interrupt Latch and Exception Entry

This block holds the external-interrupt state of a small 32-bit RISC core. Thirty-two request lines feed a sticky pending register: any line seen at level 1 on a clock edge sets its pending bit, and the bit stays set after the line falls. Software sees four control registers through one read/write port: an enable register, a mask register, the pending register and an exception base register.

At each instruction boundary flagged by the core, the block decides whether to take an interrupt. It takes one when the global enable bit is set and at least one pending bit is also unmasked. When it takes one, it raises a one-cycle redirect pulse. With that pulse it presents the PC to save, the general register index that receives it, and the handler address. The handler address is the base register plus the interrupt exception ID times the 32-byte slot size. In the same step it moves the enable bit into a saved-enable bit. An exception-return strobe copies the saved bit back.

A three-state controller decides when the check is owed. In `ST_QUIET` nothing is owed and boundaries are ignored. Any line at level 1 moves it to `ST_ARMED` (transition *arm*). In `ST_ARMED`, a boundary whose condition holds moves it to `ST_REDIRECT` (transition *fire*). A boundary that fails while no line is active returns it to `ST_QUIET` (transition *settle*). A boundary that fails while a line is still active keeps it in `ST_ARMED` (transition *hold*), so it checks again at the next boundary. `ST_REDIRECT` lasts one cycle. It then returns to `ST_ARMED` if a line is active (*rearm*) and to `ST_QUIET` otherwise (*finish*).

Top module: `irq_entry_unit`

## Requirements
- R1: A line n at level 1 on a clock edge sets pending bit n. The pending register reads back through `csr_sel_i` = 2 (0 = enable, 1 = mask, 2 = pending, 3 = base), and the read is combinational.
- R2: A pending bit stays set after its line returns to 0.
- R3: Writing the pending register clears every bit written as 1 (write-one-to-clear). A line at level 1 in the same cycle keeps its bit set.
- R4: The block takes an interrupt only at a boundary (`boundary_i` = 1) in `ST_ARMED`, with enable bit 0 set and (mask AND pending) non-zero. `take_o` is high in the cycle after that edge.
- R5: While `take_o` is high, `save_pc_o` holds `cur_pc_i` from the deciding edge, and `epc_reg_o` reads 30.
- R6: While `take_o` is high, `target_pc_o` equals the base register plus the exception ID (default 6) times 32. With the default settings that offset is 0xC0.
- R7: Taking an interrupt sets the enable register to 0b10: enable cleared, saved-enable set. This takes priority over a software write in the same cycle.
- R8: After a failed check, a later mask or enable write releases the interrupt at the next boundary only if some line is still at level 1. If every line fell before the failed check, the later write causes no take.
- R9: `eret_i` copies enable bit 1 into enable bit 0.
- R10: Reset clears the enable, mask and pending registers and loads the base register with RESET_VEC (0x0000_8000 by default). The base register's low 8 bits always read zero.
- R11: `take_o` lasts exactly one cycle, and no interrupt is taken while enable bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 32 | Interrupt request levels, bit n is line n |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| cur_pc_i | input | 32 | PC to save if the interrupt is taken |
| eret_i | input | 1 | Exception return: restore enable from saved-enable |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register select: 0 enable, 1 mask, 2 pending, 3 base |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Selected register, combinational |
| take_o | output | 1 | One-cycle redirect pulse |
| epc_reg_o | output | 5 | General register index that receives the saved PC |
| save_pc_o | output | 32 | PC to save, valid with `take_o` |
| target_pc_o | output | 32 | Handler address, valid with `take_o` |

## Verification
Pending, mask, enable and base updates appear one edge after the line level or write strobe that causes them, and register reads are combinational. `take_o`, `save_pc_o` and `target_pc_o` follow the deciding boundary edge by one register stage. An interrupt line raised at edge k can therefore fire no earlier than a boundary at edge k+1, with the redirect visible after that edge. The bench drives inputs on falling edges and samples on the next falling edge, so each check reads exactly one rising edge after its stimulus. Redirect checks are made in the single cycle `take_o` is high, and a check one cycle later confirms the pulse has ended.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_PEND   = 2'd2,
        SEL_BASE   = 2'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        ST_QUIET    = 2'd0,
        ST_ARMED    = 2'd1,
        ST_REDIRECT = 2'd2
    } entry_state_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic                 clr_we_i,
    input  logic [NUM_LINES-1:0] clr_bits_i,
    output logic [NUM_LINES-1:0] pend_o
);
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (lines_i[n])
                bit_q <= 1'b1;
            else if (clr_we_i && clr_bits_i[n])
                bit_q <= 1'b0;
        end
        assign pend_o[n] = bit_q;
    end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_entry_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter int               BASE_LSB  = 8,
    parameter logic [XLEN-1:0]  RESET_VEC = 32'h0000_8000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  csr_sel_e        sel_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            take_i,
    input  logic            eret_i,
    output logic [1:0]      ie_o,
    output logic [XLEN-1:0] mask_o,
    output logic [XLEN-1:0] base_o
);
    logic [1:0]             ie_q;
    logic [XLEN-1:0]        mask_q;
    logic [XLEN-1:BASE_LSB] base_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 2'b00;
        end else if (take_i) begin
            ie_q <= 2'b10;
        end else if (eret_i) begin
            ie_q[0] <= ie_q[1];
        end else if (we_i && sel_i == SEL_ENABLE) begin
            ie_q <= wdata_i[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            base_hi_q <= RESET_VEC[XLEN-1:BASE_LSB];
        end else if (we_i) begin
            unique case (sel_i)
                SEL_MASK: mask_q    <= wdata_i;
                SEL_BASE: base_hi_q <= wdata_i[XLEN-1:BASE_LSB];
                default:  ;
            endcase
        end
    end

    assign ie_o   = ie_q;
    assign mask_o = mask_q;
    assign base_o = {base_hi_q, {BASE_LSB{1'b0}}};
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NUM_LINES  = 32,
    parameter int VEC_OFFSET = 192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic                 boundary_i,
    input  logic                 ie0_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [XLEN-1:0]      cur_pc_i,
    input  logic [XLEN-1:0]      base_i,
    output logic                 fire_o,
    output logic                 take_o,
    output logic [XLEN-1:0]      save_pc_o,
    output logic [XLEN-1:0]      target_o
);
    entry_state_e state_q, state_d;
    logic         any_live;
    logic         cond_ok;
    logic [XLEN-1:0] save_q, target_q;

    assign any_live = |lines_i;
    assign cond_ok  = ie0_i && |(mask_i & pend_i);
    assign fire_o   = (state_q == ST_ARMED) && boundary_i && cond_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:    if (any_live) state_d = ST_ARMED;
            ST_ARMED: begin
                if (fire_o)                       state_d = ST_REDIRECT;
                else if (boundary_i && !any_live) state_d = ST_QUIET;
            end
            ST_REDIRECT: state_d = any_live ? ST_ARMED : ST_QUIET;
            default:     state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q   <= '0;
            target_q <= '0;
        end else if (fire_o) begin
            save_q   <= cur_pc_i;
            target_q <= base_i + XLEN'(VEC_OFFSET);
        end
    end

    always_comb begin
        take_o    = (state_q == ST_REDIRECT);
        save_pc_o = save_q;
        target_o  = target_q;
    end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              NUM_LINES  = 32,
    parameter int              GPR_COUNT  = 32,
    parameter int              EPC_REG    = 30,
    parameter int              EXC_ID     = 6,
    parameter int              SLOT_BYTES = 32,
    parameter int              BASE_LSB   = 8,
    parameter logic [XLEN-1:0] RESET_VEC  = 32'h0000_8000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LINES-1:0]     irq_lines_i,
    input  logic                     boundary_i,
    input  logic [XLEN-1:0]          cur_pc_i,
    input  logic                     eret_i,
    input  logic                     csr_we_i,
    input  logic [1:0]               csr_sel_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic [XLEN-1:0]          csr_rdata_o,
    output logic                     take_o,
    output logic [$clog2(GPR_COUNT)-1:0] epc_reg_o,
    output logic [XLEN-1:0]          save_pc_o,
    output logic [XLEN-1:0]          target_pc_o
);
    localparam int GPR_AW     = $clog2(GPR_COUNT);
    localparam int VEC_OFFSET = EXC_ID * SLOT_BYTES;

    csr_sel_e        sel;
    logic [1:0]      ie_w;
    logic [XLEN-1:0] mask_w, base_w;
    logic [NUM_LINES-1:0] pend_w;
    logic            fire_w;

    assign sel = csr_sel_e'(csr_sel_i);

    irq_pend_reg #(.NUM_LINES(NUM_LINES)) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_i    (irq_lines_i),
        .clr_we_i   (csr_we_i && sel == SEL_PEND),
        .clr_bits_i (csr_wdata_i[NUM_LINES-1:0]),
        .pend_o     (pend_w)
    );

    irq_ctl_regs #(.XLEN(XLEN), .BASE_LSB(BASE_LSB), .RESET_VEC(RESET_VEC)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (csr_we_i),
        .sel_i   (sel),
        .wdata_i (csr_wdata_i),
        .take_i  (fire_w),
        .eret_i  (eret_i),
        .ie_o    (ie_w),
        .mask_o  (mask_w),
        .base_o  (base_w)
    );

    irq_entry_fsm #(.XLEN(XLEN), .NUM_LINES(NUM_LINES), .VEC_OFFSET(VEC_OFFSET)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_i    (irq_lines_i),
        .boundary_i (boundary_i),
        .ie0_i      (ie_w[0]),
        .mask_i     (mask_w[NUM_LINES-1:0]),
        .pend_i     (pend_w),
        .cur_pc_i   (cur_pc_i),
        .base_i     (base_w),
        .fire_o     (fire_w),
        .take_o     (take_o),
        .save_pc_o  (save_pc_o),
        .target_o   (target_pc_o)
    );

    always_comb begin
        unique case (sel)
            SEL_ENABLE: csr_rdata_o = {{(XLEN-2){1'b0}}, ie_w};
            SEL_MASK:   csr_rdata_o = mask_w;
            SEL_PEND:   csr_rdata_o = XLEN'(pend_w);
            SEL_BASE:   csr_rdata_o = base_w;
            default:    csr_rdata_o = '0;
        endcase
    end

    assign epc_reg_o = GPR_AW'(EPC_REG);
endmodule

// File: rtl/irq_entry_checker.sv
module irq_entry_checker #(
    parameter int XLEN       = 32,
    parameter int NUM_LINES  = 32,
    parameter int VEC_OFFSET = 192
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines_i,
    input logic                 boundary_i,
    input logic [XLEN-1:0]      cur_pc_i,
    input logic                 csr_we_i,
    input logic [1:0]           csr_sel_i,
    input logic                 take_o,
    input logic [XLEN-1:0]      save_pc_o,
    input logic [XLEN-1:0]      target_pc_o,
    input logic [1:0]           ie_w,
    input logic [XLEN-1:0]      mask_w,
    input logic [XLEN-1:0]      base_w,
    input logic [NUM_LINES-1:0] pend_w
);
    p_pend_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines_i) |=> ((pend_w & $past(irq_lines_i)) == $past(irq_lines_i)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we_i && csr_sel_i == 2'd2) |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

    p_take_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> ($past(boundary_i) && $past(ie_w[0])
                           && ($past(mask_w[NUM_LINES-1:0] & pend_w) != '0)));

    p_epc_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> (save_pc_o == $past(cur_pc_i)));

    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> (target_pc_o == $past(base_w) + XLEN'(VEC_OFFSET)));

    p_ie_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> (ie_w == 2'b10));

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

bind irq_entry_unit irq_entry_checker #(
    .XLEN(XLEN), .NUM_LINES(NUM_LINES), .VEC_OFFSET(EXC_ID * SLOT_BYTES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines_i), .boundary_i(boundary_i),
    .cur_pc_i(cur_pc_i), .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i),
    .take_o(take_o), .save_pc_o(save_pc_o), .target_pc_o(target_pc_o),
    .ie_w(ie_w), .mask_w(mask_w), .base_w(base_w), .pend_w(pend_w)
);

// File: tb/test_irq_entry_unit.sv
module test_irq_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_lines_i;
    logic        boundary_i;
    logic [31:0] cur_pc_i;
    logic        eret_i;
    logic        csr_we_i;
    logic [1:0]  csr_sel_i;
    logic [31:0] csr_wdata_i;
    logic [31:0] csr_rdata_o;
    logic        take_o;
    logic [4:0]  epc_reg_o;
    logic [31:0] save_pc_o;
    logic [31:0] target_pc_o;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] RST_VEC = 32'h0000_8000;
    localparam logic [31:0] OFFS    = 32'd192;

    always #4 clk = ~clk;

    irq_entry_unit i_irq_entry_unit (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines_i), .boundary_i(boundary_i),
        .cur_pc_i(cur_pc_i), .eret_i(eret_i), .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i),
        .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .take_o(take_o),
        .epc_reg_o(epc_reg_o), .save_pc_o(save_pc_o), .target_pc_o(target_pc_o)
    );

    // {lines, mask, ie0, expect_take}
    localparam logic [65:0] VEC [6] = '{
        {32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1},
        {32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1},
        {32'h0000_0010, 32'h0000_0020, 1'b1, 1'b0},
        {32'h0000_0010, 32'hFFFF_FFFF, 1'b0, 1'b0},
        {32'h00F0_0000, 32'h0010_0000, 1'b1, 1'b1},
        {32'h0000_0000, 32'h0000_FFFF, 1'b1, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_lines_i = '0; boundary_i = 1'b0; cur_pc_i = '0;
        eret_i = 1'b0; csr_we_i = 1'b0; csr_sel_i = 2'd0; csr_wdata_i = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] data);
        csr_we_i = 1'b1; csr_sel_i = sel; csr_wdata_i = data;
        tick();
        csr_we_i = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] sel, output logic [31:0] data);
        csr_sel_i = sel;
        #1;
        data = csr_rdata_o;
    endtask

    task automatic boundary_step();
        boundary_i = 1'b1;
        tick();
        boundary_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // R10 reset state
        csr_read(2'd0, rd); check("R10 enable", rd, 32'd0);
        csr_read(2'd1, rd); check("R10 mask", rd, 32'd0);
        csr_read(2'd2, rd); check("R10 pending", rd, 32'd0);
        csr_read(2'd3, rd); check("R10 base", rd, RST_VEC);
        check("R10 take", 32'(take_o), 32'd0);

        // table walk: R1, R4, R5, R6, R7, R11
        for (int i = 0; i < 6; i++) begin
            logic [31:0] ln, mk, pc;
            logic        ie, ex;
            {ln, mk, ie, ex} = VEC[i];
            pc = 32'h0000_4A00 + 32'(i * 4);
            do_reset();
            csr_write(2'd1, mk);
            csr_write(2'd0, {31'd0, ie});
            irq_lines_i = ln; cur_pc_i = pc;
            tick();
            irq_lines_i = '0;
            csr_read(2'd2, rd); check("R1 pending", rd, ln);
            boundary_step();
            check("R4 take", 32'(take_o), 32'(ex));
            if (ex) begin
                check("R5 save_pc", save_pc_o, pc);
                check("R5 epc_reg", 32'(epc_reg_o), 32'd30);
                check("R6 target", target_pc_o, RST_VEC + OFFS);
                csr_read(2'd0, rd); check("R7 enable", rd, 32'd2);
            end
            tick();
            check("R11 pulse end", 32'(take_o), 32'd0);
        end

        // R2 sticky, R3 write-one-to-clear
        do_reset();
        irq_lines_i = 32'h3; tick(); irq_lines_i = '0; tick(); tick();
        csr_read(2'd2, rd); check("R2 sticky", rd, 32'h3);
        csr_write(2'd2, 32'h1);
        csr_read(2'd2, rd); check("R3 clear", rd, 32'h2);
        irq_lines_i = 32'h2;
        csr_write(2'd2, 32'h2);
        irq_lines_i = '0;
        csr_read(2'd2, rd); check("R3 set wins", rd, 32'h2);
        csr_write(2'd2, 32'h2);
        csr_read(2'd2, rd); check("R3 clear after drop", rd, 32'h0);

        // R8 held line released by later mask write
        do_reset();
        csr_write(2'd0, 32'h1);
        irq_lines_i = 32'h100; cur_pc_i = 32'h0000_5000;
        tick();
        boundary_step();
        check("R8 held no take", 32'(take_o), 32'd0);
        tick();
        csr_write(2'd1, 32'h100);
        boundary_step();
        check("R8 released", 32'(take_o), 32'd1);
        check("R5 save_pc held", save_pc_o, 32'h0000_5000);
        tick();
        // R11 no take while enable clear, line still active
        boundary_step();
        check("R11 no take ie0 clear", 32'(take_o), 32'd0);
        irq_lines_i = '0;
        // R9 exception return
        csr_read(2'd0, rd); check("R9 before eret", rd, 32'd2);
        eret_i = 1'b1; tick(); eret_i = 1'b0;
        csr_read(2'd0, rd); check("R9 after eret", rd, 32'd3);

        // R8 dropped line: no release
        do_reset();
        csr_write(2'd0, 32'h1);
        irq_lines_i = 32'h4; tick(); irq_lines_i = '0;
        boundary_step();
        check("R8 fail check", 32'(take_o), 32'd0);
        csr_write(2'd1, 32'h4);
        boundary_step();
        check("R8 dropped no take", 32'(take_o), 32'd0);

        // R10 base low bits, R6 with written base
        do_reset();
        csr_write(2'd3, 32'h1234_5678);
        csr_read(2'd3, rd); check("R10 base low zero", rd, 32'h1234_5600);
        csr_write(2'd1, 32'h1);
        csr_write(2'd0, 32'h1);
        irq_lines_i = 32'h1; tick(); irq_lines_i = '0;
        boundary_step();
        check("R6 take", 32'(take_o), 32'd1);
        check("R6 target written base", target_pc_o, 32'h1234_56C0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule